// File: doc/BRIEF.md
# GPIO Controller with Clock Output

This block drives and samples sixteen general-purpose pins through a small register port. Every pin has a direction bit and an output data bit. Every pin is read back through a two-flop synchronizer. Only the low thirteen pins can raise interrupts. Each of those pins has its own enable bit and its own 2-bit trigger type. The trigger can be either level or edge. Edge events are held in sticky status bits. Software clears them by writing a one to them. A single interrupt line reports any enabled status bit that is set.

Pin 14 can also be switched away from its register control so that it drives a clock divided from the system clock. The high phase and the low phase each have a programmable length. A small state machine generates this clock. Its states are `CK_OFF` (clock idle, pin under register control), `CK_HIGH` (pin driven high) and `CK_LOW` (pin driven low). Its transitions are:

- **start**: `CK_OFF`→`CK_HIGH` when the enable bit is set.
- **fall**: `CK_HIGH`→`CK_LOW` when the high count is used up.
- **repeat**: `CK_LOW`→`CK_HIGH` when the low count is used up and the enable bit is still set.
- **stop**: `CK_LOW`→`CK_OFF` when the low count is used up and the enable bit is clear.

The phase lengths are captured on every entry to `CK_HIGH`. A new setting therefore applies from the next period. Disabling the clock lets the current period finish before the pin returns to register control.

Top module: `gpio_clkout_ctrl`

## Requirements
- R1: While reset is low and right after it, every output enable and output data bit is 0, `irq` is 0, and every register reads 0.
- R2: For every pin except pin 14 while its clock runs, `gpio_oe[i]` equals direction bit i (1 = output) and `gpio_out[i]` equals output data bit i.
- R3: The input register (offset 2) returns the value that `gpio_in` had two clock edges earlier. Writes to it have no effect.
- R4: Interrupt enable bits for pins 13 to 15 are ignored on write and read as 0. Bits 10 to 15 of the upper type register also read as 0.
- R5: The type of pin i sits at bits [2i+1:2i] of offset 4 for i<8, and at bits [2(i-8)+1:2(i-8)] of offset 5 for 8≤i≤12. The codes are 00 for high level, 01 for low level, 10 for rising edge and 11 for falling edge. Edges are found by comparing the current synchronized sample with the previous one.
- R6: An edge status bit is set one edge after the synchronized edge, but only if that pin is enabled. It then holds until a one is written to it at offset 6. A new event in the same cycle as a clear wins over the clear.
- R7: A level status bit equals (enabled AND level condition) on the synchronized sample, one edge late. Writes to offset 6 do not change it.
- R8: `irq` is the OR over pins 0 to 12 of (status AND enable). Pins 13 to 15 never affect it, and a cleared enable masks a sticky bit.
- R9: Setting bit 0 of offset 7 makes pin 14 an output that is high for H+1 cycles and then low for L+1 cycles. H is bits [7:4] and L is bits [11:8].
- R10: H and L are captured only when a period starts. Clearing bit 0 lets the running period finish, and pin 14 then follows its direction and data bits again.
- R11: The register offsets are 0 for direction, 1 for output data, 2 for input, 3 for interrupt enable, 4 and 5 for type, 6 for status and 7 for clock configuration. All of them read back over `reg_rdata` in the same cycle as `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| gpio_in | input | 16 | Pin input levels |
| gpio_out | output | 16 | Pin output levels |
| gpio_oe | output | 16 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: sixteen pins, thirteen interrupt pins, the clock on pin 14 and 4-bit phase counts. With these values the clock can be driven at both ends of its range. Counts of zero give a clock at half the system rate, and counts of fifteen give a sixteen-cycle phase. The bench also covers the unused type bits above pin 12 and the enable bits of the pins without interrupts. A behavioural model follows every register, synchronizer stage, status bit and clock phase. It is compared with the outputs on every cycle under pseudo-random pin activity.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_DIR   = 3'd0;
    localparam logic [ADDR_W-1:0] A_DOUT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIN   = 3'd2;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_ITLO  = 3'd4;
    localparam logic [ADDR_W-1:0] A_ITHI  = 3'd5;
    localparam logic [ADDR_W-1:0] A_ISTAT = 3'd6;
    localparam logic [ADDR_W-1:0] A_CKCFG = 3'd7;

    // field positions inside the clock configuration register
    localparam int CK_EN_BIT = 0;
    localparam int CK_HI_LSB = 4;
    localparam int CK_LO_LSB = 8;

    typedef enum logic [1:0] {
        CK_OFF  = 2'd0,
        CK_HIGH = 2'd1,
        CK_LOW  = 2'd2
    } ck_state_e;

    typedef enum logic [1:0] {
        IT_LVL_HI = 2'b00,
        IT_LVL_LO = 2'b01,
        IT_RISE   = 2'b10,
        IT_FALL   = 2'b11
    } irq_type_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_pkg::*;
#(
    parameter int NIRQ = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIRQ-1:0]   pin_s,
    input  logic [NIRQ-1:0]   ien,
    input  logic [2*NIRQ-1:0] itype,
    input  logic [NIRQ-1:0]   clr,
    output logic [NIRQ-1:0]   stat
);

    logic [NIRQ-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= pin_s;
        end
    end

    for (genvar i = 0; i < NIRQ; i++) begin : g_pin
        irq_type_e ty;
        logic      hit;
        logic      st_q;

        assign ty = irq_type_e'(itype[2*i +: 2]);

        always_comb begin
            unique case (ty)
                IT_LVL_HI: hit = pin_s[i];
                IT_LVL_LO: hit = !pin_s[i];
                IT_RISE:   hit = pin_s[i] && !prev_q[i];
                IT_FALL:   hit = !pin_s[i] && prev_q[i];
                default:   hit = 1'b0;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= 1'b0;
            end else if (ty == IT_RISE || ty == IT_FALL) begin
                st_q <= (ien[i] && hit) || (st_q && !clr[i]);
            end else begin
                st_q <= ien[i] && hit;
            end
        end

        assign stat[i] = st_q;
    end

endmodule

// File: rtl/gpio_clkgen.sv
module gpio_clkgen
    import gpio_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] hi_cfg,
    input  logic [CNT_W-1:0] lo_cfg,
    output logic             active,
    output logic             level,
    output logic [CNT_W-1:0] hi_lat,
    output logic [CNT_W-1:0] lo_lat
);

    ck_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] hi_q, lo_q;
    logic             period_start;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_OFF:  if (en) state_d = CK_HIGH;
            CK_HIGH: if (cnt_q == hi_q) state_d = CK_LOW;
            CK_LOW:  if (cnt_q == lo_q) state_d = en ? CK_HIGH : CK_OFF;
            default: state_d = CK_OFF;
        endcase
    end

    assign period_start = (state_d == CK_HIGH) && (state_q != CK_HIGH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CK_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // phase counter and per-period capture of the phase lengths
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else begin
            if (state_d == CK_OFF || state_d != state_q) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (period_start) begin
                hi_q <= hi_cfg;
                lo_q <= lo_cfg;
            end
        end
    end

    // outputs
    always_comb begin
        active = 1'b0;
        level  = 1'b0;
        unique case (state_q)
            CK_OFF:  ;
            CK_HIGH: begin active = 1'b1; level = 1'b1; end
            CK_LOW:  active = 1'b1;
            default: ;
        endcase
    end

    assign hi_lat = hi_q;
    assign lo_lat = lo_q;

endmodule

// File: rtl/gpio_clkout_ctrl.sv
module gpio_clkout_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS   = 16,
    parameter int NIRQ    = 13,
    parameter int CLK_PIN = 14,
    parameter int CNT_W   = 4,
    parameter int SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  gpio_in,
    output logic [NPINS-1:0]  gpio_out,
    output logic [NPINS-1:0]  gpio_oe,
    output logic              irq
);

    localparam int ITW = 2 * NIRQ;
    localparam int PADW = 2 * NPINS;

    logic [NPINS-1:0] dir_q, dout_q, pin_s;
    logic [NIRQ-1:0]  ien_q, stat, clr;
    logic [ITW-1:0]   itype_q;
    logic [PADW-1:0]  itype_pad, itype_nxt;
    logic             ck_en_q;
    logic [CNT_W-1:0] ck_hi_q, ck_lo_q, hi_lat, lo_lat;
    logic             ck_active, ck_level;

    gpio_sync #(.W(NPINS), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gpio_in),
        .q     (pin_s)
    );

    assign clr = (reg_we && reg_addr == A_ISTAT) ? reg_wdata[NIRQ-1:0] : '0;

    gpio_irq_unit #(.NIRQ(NIRQ)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_s (pin_s[NIRQ-1:0]),
        .ien   (ien_q),
        .itype (itype_q),
        .clr   (clr),
        .stat  (stat)
    );

    gpio_clkgen #(.CNT_W(CNT_W)) u_ck (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ck_en_q),
        .hi_cfg (ck_hi_q),
        .lo_cfg (ck_lo_q),
        .active (ck_active),
        .level  (ck_level),
        .hi_lat (hi_lat),
        .lo_lat (lo_lat)
    );

    // type fields live in two registers; pad to two full words
    assign itype_pad = PADW'(itype_q);

    always_comb begin
        itype_nxt = itype_pad;
        if (reg_we && reg_addr == A_ITLO) itype_nxt[NPINS-1:0]     = reg_wdata;
        if (reg_we && reg_addr == A_ITHI) itype_nxt[PADW-1:NPINS]  = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            dout_q  <= '0;
            ien_q   <= '0;
            itype_q <= '0;
            ck_en_q <= 1'b0;
            ck_hi_q <= '0;
            ck_lo_q <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                A_DIR:   dir_q  <= reg_wdata;
                A_DOUT:  dout_q <= reg_wdata;
                A_DIN:   ;
                A_IEN:   ien_q  <= reg_wdata[NIRQ-1:0];
                A_ITLO,
                A_ITHI:  itype_q <= itype_nxt[ITW-1:0];
                A_ISTAT: ;
                A_CKCFG: begin
                    ck_en_q <= reg_wdata[CK_EN_BIT];
                    ck_hi_q <= reg_wdata[CK_HI_LSB +: CNT_W];
                    ck_lo_q <= reg_wdata[CK_LO_LSB +: CNT_W];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_DIR:   reg_rdata = dir_q;
            A_DOUT:  reg_rdata = dout_q;
            A_DIN:   reg_rdata = pin_s;
            A_IEN:   reg_rdata = NPINS'(ien_q);
            A_ITLO:  reg_rdata = itype_pad[NPINS-1:0];
            A_ITHI:  reg_rdata = itype_pad[PADW-1:NPINS];
            A_ISTAT: reg_rdata = NPINS'(stat);
            A_CKCFG: begin
                reg_rdata[CK_EN_BIT]           = ck_en_q;
                reg_rdata[CK_HI_LSB +: CNT_W]  = ck_hi_q;
                reg_rdata[CK_LO_LSB +: CNT_W]  = ck_lo_q;
            end
            default: ;
        endcase
    end

    always_comb begin
        gpio_oe  = dir_q;
        gpio_out = dout_q;
        if (ck_active) begin
            gpio_oe[CLK_PIN]  = 1'b1;
            gpio_out[CLK_PIN] = ck_level;
        end
    end

    assign irq = |(stat & ien_q);

endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int NPINS   = 16,
    parameter int NIRQ    = 13,
    parameter int CLK_PIN = 14,
    parameter int CNT_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NPINS-1:0]  reg_wdata,
    input logic [NPINS-1:0]  reg_rdata,
    input logic [NPINS-1:0]  gpio_in,
    input logic [NPINS-1:0]  gpio_oe,
    input logic              irq,
    input logic [NIRQ-1:0]   ien_q,
    input logic [NIRQ-1:0]   stat,
    input logic [2*NIRQ-1:0] itype_q,
    input logic              ck_active,
    input logic              ck_level,
    input logic [CNT_W-1:0]  hi_lat
);

    localparam int MAXRUN = 1 << CNT_W;

    int unsigned since_rst;
    int unsigned hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 0;
            hi_run    <= 0;
        end else begin
            if (since_rst < 8) since_rst <= since_rst + 1;
            hi_run <= (ck_active && ck_level) ? hi_run + 1 : 0;
        end
    end

    // R3
    din_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3 && reg_addr == A_DIN) |-> reg_rdata == $past(gpio_in, 2));

    // R4
    ien_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_IEN) |-> reg_rdata[NPINS-1:NIRQ] == '0);

    // R6
    edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[0] && itype_q[1] && !(reg_we && reg_addr == A_ISTAT && reg_wdata[0])
         && !(reg_we && reg_addr == A_ITLO)) |=> stat[0]);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

    // R9
    clk_pin_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ck_active |-> gpio_oe[CLK_PIN]);

    // R9
    high_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= MAXRUN);

    // R10
    period_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_level && $past(ck_level)) |-> $stable(hi_lat));

endmodule

bind gpio_clkout_ctrl gpio_ctrl_chk #(
    .NPINS(NPINS), .NIRQ(NIRQ), .CLK_PIN(CLK_PIN), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .gpio_in   (gpio_in),
    .gpio_oe   (gpio_oe),
    .irq       (irq),
    .ien_q     (ien_q),
    .stat      (stat),
    .itype_q   (itype_q),
    .ck_active (ck_active),
    .ck_level  (ck_level),
    .hi_lat    (hi_lat)
);

// File: tb/gpio_clkout_ctrl_test.sv
module gpio_clkout_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [15:0] gpio_in;
    logic [15:0] gpio_out;
    logic [15:0] gpio_oe;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    string irq_tag = "R8";
    string ck_tag  = "R9";

    always #5 clk = ~clk;

    gpio_clkout_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_dir, m_dout, m_ien, m_stat, m_s1, m_s2, m_prev;
    logic [25:0] m_it;
    int m_ck_en, m_hi, m_lo, m_ph, m_cnt, m_hl, m_ll;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 0; m_dout = 0; m_ien = 0; m_stat = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_it = 0;
            m_ck_en = 0; m_hi = 0; m_lo = 0; m_ph = 0; m_cnt = 0; m_hl = 0; m_ll = 0;
        end else begin
            // clock phases: 0 idle, 1 high, 2 low
            if (m_ph == 0) begin
                if (m_ck_en != 0) begin m_ph = 1; m_cnt = 0; m_hl = m_hi; m_ll = m_lo; end
            end else if (m_ph == 1) begin
                if (m_cnt == m_hl) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
            end else begin
                if (m_cnt == m_ll) begin
                    m_cnt = 0;
                    if (m_ck_en != 0) begin m_ph = 1; m_hl = m_hi; m_ll = m_lo; end
                    else m_ph = 0;
                end else m_cnt++;
            end
            // interrupt status
            for (int i = 0; i < 13; i++) begin
                int ty;
                bit cond, clr;
                ty = int'(m_it[2*i +: 2]);
                case (ty)
                    0: cond = m_s2[i];
                    1: cond = !m_s2[i];
                    2: cond = m_s2[i] && !m_prev[i];
                    default: cond = !m_s2[i] && m_prev[i];
                endcase
                clr = reg_we && reg_addr == 6 && reg_wdata[i];
                if (ty >= 2) m_stat[i] = (m_ien[i] && cond) || (m_stat[i] && !clr);
                else         m_stat[i] = m_ien[i] && cond;
            end
            m_prev = m_s2; m_s2 = m_s1; m_s1 = gpio_in;
            if (reg_we) begin
                case (reg_addr)
                    0: m_dir = reg_wdata;
                    1: m_dout = reg_wdata;
                    3: m_ien = reg_wdata & 16'h1FFF;
                    4: m_it[15:0] = reg_wdata;
                    5: m_it[25:16] = reg_wdata[9:0];
                    7: begin
                        m_ck_en = int'(reg_wdata[0]);
                        m_hi = int'(reg_wdata[7:4]);
                        m_lo = int'(reg_wdata[11:8]);
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [15:0] exp_rd();
        logic [15:0] v;
        case (reg_addr)
            0: v = m_dir;
            1: v = m_dout;
            2: v = m_s2;
            3: v = m_ien;
            4: v = m_it[15:0];
            5: v = {6'd0, m_it[25:16]};
            6: v = m_stat;
            default: v = {4'd0, 4'(m_lo), 4'(m_hi), 3'd0, 1'(m_ck_en)};
        endcase
        return v;
    endfunction

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // compare every cycle, 2 ns after the rising edge
    always @(posedge clk) begin
        #2;
        if (!done) begin
            logic [15:0] eoe, eout;
            string rtag;
            eoe = m_dir; eout = m_dout;
            if (m_ph != 0) begin eoe[14] = 1'b1; eout[14] = (m_ph == 1); end
            if (!rst_n) begin
                chk("R1", "oe", gpio_oe, eoe);
                chk("R1", "out", gpio_out, eout);
                chk("R1", "irq", {15'd0, irq}, 16'd0);
                chk("R1", "rdata", reg_rdata, exp_rd());
            end else begin
                chk("R2", "oe", gpio_oe & 16'hBFFF, eoe & 16'hBFFF);
                chk("R2", "out", gpio_out & 16'hBFFF, eout & 16'hBFFF);
                chk(ck_tag, "pin14 oe", {15'd0, gpio_oe[14]}, {15'd0, eoe[14]});
                chk(ck_tag, "pin14 out", {15'd0, gpio_out[14]}, {15'd0, eout[14]});
                chk(irq_tag, "irq", {15'd0, irq}, {15'd0, |(m_stat & m_ien)});
                case (reg_addr)
                    2: rtag = "R3";
                    3, 5: rtag = "R4";
                    6: rtag = irq_tag;
                    7: rtag = ck_tag;
                    default: rtag = "R11";
                endcase
                chk(rtag, "rdata", reg_rdata, exp_rd());
            end
        end
    end

    // ---------------- stimulus ----------------
    logic [15:0] lf = 16'hACE1;
    function automatic logic [15:0] lfsr_next(logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    task automatic wr(logic [2:0] a, logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(int n, logic [15:0] mask);
        for (int k = 0; k < n; k++) begin
            lf = lfsr_next(lf);
            gpio_in = (gpio_in & ~mask) | (lf & mask);
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 16'd0; gpio_in = 16'hFFFF;
        for (int a = 0; a < 8; a++) begin
            if (a != 2) reg_addr = 3'(a);
            @(negedge clk);
        end
        // R1 explicit reset state
        chk("R1", "oe at reset", gpio_oe, 16'h0000);
        chk("R1", "irq at reset", {15'd0, irq}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out after reset", gpio_out, 16'h0000);

        // R11 / R2: register map and pin drive
        wr(3'd0, 16'hA5C3); wr(3'd1, 16'h3C5A);
        reg_addr = 3'd0; @(negedge clk);
        chk("R11", "direction readback", reg_rdata, 16'hA5C3);
        chk("R2", "oe follows direction", gpio_oe, 16'hA5C3);
        reg_addr = 3'd1; @(negedge clk);
        chk("R2", "out follows data", gpio_out, 16'h3C5A);
        wr(3'd0, 16'h0000);

        // R3: synchronized input, writes ignored
        wr(3'd2, 16'h1234);
        reg_addr = 3'd2;
        idle(20, 16'hFFFF);
        gpio_in = 16'h5AA5; idle(2, 16'h0000);
        chk("R3", "input after two edges", reg_rdata, 16'h5AA5);

        // R4: upper enables and type bits ignored
        wr(3'd3, 16'hFFFF); reg_addr = 3'd3; @(negedge clk);
        chk("R4", "enable readback", reg_rdata, 16'h1FFF);
        wr(3'd5, 16'hFFFF); reg_addr = 3'd5; @(negedge clk);
        chk("R4", "upper type readback", reg_rdata, 16'h03FF);

        // R5: mixed trigger types
        irq_tag = "R5";
        wr(3'd4, 16'hAA4E); wr(3'd5, 16'h02E7);
        reg_addr = 3'd6;
        idle(40, 16'hFFFF);

        // R6: sticky edges and write-one-to-clear
        irq_tag = "R6";
        wr(3'd4, 16'hFFAA); wr(3'd5, 16'h03FF);
        idle(10, 16'h1FFF);
        for (int k = 0; k < 12; k++) begin
            lf = lfsr_next(lf); gpio_in = lf;
            wr(3'd6, (k % 2 == 0) ? 16'hFFFF : 16'h00F0);
        end
        gpio_in = 16'h0000; idle(4, 16'h0000);
        wr(3'd6, 16'hFFFF); @(negedge clk);
        chk("R6", "all cleared", reg_rdata, 16'h0000);

        // R7: level status ignores clear writes
        irq_tag = "R7";
        wr(3'd4, 16'h5500); wr(3'd5, 16'h0155);
        gpio_in = 16'h0F0F; idle(3, 16'h0000);
        for (int k = 0; k < 6; k++) wr(3'd6, 16'hFFFF);
        idle(20, 16'h1FFF);

        // R8: upper pins never interrupt, disabled enable masks sticky bits
        irq_tag = "R8";
        wr(3'd4, 16'hAAAA); wr(3'd5, 16'h02AA);
        gpio_in = 16'h0000; idle(3, 16'h0000);
        wr(3'd6, 16'hFFFF); @(negedge clk);
        idle(20, 16'hE000);
        chk("R8", "upper pins quiet", {15'd0, irq}, 16'h0000);
        gpio_in = 16'h0001; idle(4, 16'h0000);
        wr(3'd3, 16'h0000); @(negedge clk);
        chk("R8", "masked sticky", {15'd0, irq}, 16'h0000);
        idle(10, 16'hFFFF);

        // R9: clock output at several settings
        ck_tag = "R9";
        reg_addr = 3'd7;
        wr(3'd1, 16'h0000);
        wr(3'd7, 16'h0211); idle(30, 16'h00FF);
        wr(3'd7, 16'h0001); idle(12, 16'h00FF);
        wr(3'd7, 16'h0FF1); idle(70, 16'h00FF);

        // R10: mid-period change, then stop
        ck_tag = "R10";
        wr(3'd7, 16'h0121); idle(3, 16'h0000);
        wr(3'd7, 16'h03F1); idle(40, 16'h0000);
        wr(3'd7, 16'h03F0); idle(40, 16'h0000);
        chk("R10", "pin14 released", {15'd0, gpio_oe[14]}, 16'h0000);

        @(negedge clk);
        done = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        done = 1;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

endmodule